// File: doc/BRIEF.md
# I2C Controller Interrupt Aggregator with Keyed Soft Reset

This block collects eight one-cycle event pulses from an I2C controller core and latches each into its own status bit. Software enables the status bits one by one and also has a single global enable bit. The block drives one interrupt line, which is high whenever an enabled status bit is set and the global enable is on.

All access goes over a plain 32-bit register bus with separate read and write strobes and a byte address. Software clears a status bit by writing a one to it. Writing one specific key word to the reset register sends a one-cycle reset pulse to the controller core and returns this block's own registers to zero. Writing any other word to that register does nothing.

Top module: `i2c_irq_top`

## Requirements
- R1: After synchronous reset the status, enable and global-enable registers are zero, and `irq_o`, `core_rst_o` and `rdata` are 0.
- R2: A one-cycle pulse on `evt[i]` sets status bit i at the next clock edge. The bit stays set until it is cleared. Bit map: 0 arbitration lost, 1 transmit error or transfer done, 2 transmit FIFO empty, 3 receive FIFO at threshold, 4 bus idle, 5 selected as target, 6 no longer selected as target, 7 transmit FIFO half empty.
- R3: A write to the status register at offset 0x20 clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register at offset 0x28 holds bits [7:0] as read/write. Its upper bits read as 0.
- R6: The global-enable register at offset 0x1C stores only bit 31. All its other bits read as 0.
- R7: `irq_o` is registered. It equals (global enable AND (status AND enable) nonzero), evaluated on the register state, and lags that state by one clock.
- R8: Writing exactly 32'h0000000A to offset 0x40 raises `core_rst_o` for exactly the one cycle after the write. The same write clears status, enable and global enable.
- R9: Writing any other value to offset 0x40 gives no reset pulse and changes no register.
- R10: Reads of offset 0x40 and of unmapped offsets return 0. Writes to unmapped offsets are ignored.
- R11: Read data is registered. `rdata` holds the addressed value in the cycle after `rd_en` and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt | input | 8 | One-cycle event pulses from the controller core |
| irq_o | output | 1 | Interrupt request |
| core_rst_o | output | 1 | One-cycle reset pulse for the controller core |

## Verification
Two things can fall in the same cycle: an event pulse setting a status bit and a software write clearing that same bit. The bench drives both in one cycle, once on a single bit and once where a second, already-set bit is cleared next to it. It then reads the status back and expects the event bit to be set and the other bit to be cleared. The same-edge clash between the keyed reset write and the register state is judged by reading every register right after the pulse.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned REG_ADDR_W = 8;
  localparam logic [REG_ADDR_W-1:0] OFS_GIE  = 8'h1C;
  localparam logic [REG_ADDR_W-1:0] OFS_STS  = 8'h20;
  localparam logic [REG_ADDR_W-1:0] OFS_IEN  = 8'h28;
  localparam logic [REG_ADDR_W-1:0] OFS_KICK = 8'h40;
  localparam logic [31:0]           KICK_KEY = 32'h0000_000A;

  typedef struct packed {
    logic gie;
    logic sts;
    logic ien;
    logic kick;
  } reg_sel_t;
endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
  import i2c_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel      = '0;
    sel.gie  = (addr == ADDR_W'(OFS_GIE));
    sel.sts  = (addr == ADDR_W'(OFS_STS));
    sel.ien  = (addr == ADDR_W'(OFS_IEN));
    sel.kick = (addr == ADDR_W'(OFS_KICK));
  end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic [N_EVT-1:0] evt,
  input  logic             wr_clr,
  input  logic [N_EVT-1:0] clr_mask,
  output logic [N_EVT-1:0] sts_q
);
  // one latch per event; a pulse outranks a same-cycle software clear
  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr_all)              sts_q[i] <= 1'b0;
      else if (evt[i])                 sts_q[i] <= 1'b1;
      else if (wr_clr && clr_mask[i])  sts_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_irq_out.sv
module i2c_irq_out #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic [N_EVT-1:0] sts,
  input  logic [N_EVT-1:0] ien,
  input  logic             gie,
  output logic             irq_q
);
  logic [N_EVT-1:0] pend;
  assign pend = sts & ien;

  always_ff @(posedge clk) begin
    if (rst || clr_all) irq_q <= 1'b0;
    else                irq_q <= gie & (|pend);
  end
endmodule

// File: rtl/i2c_irq_top.sv
module i2c_irq_top
  import i2c_irq_pkg::*;
#(
  parameter int unsigned N_EVT  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_EVT-1:0]  evt,
  output logic              irq_o,
  output logic              core_rst_o
);
  localparam int unsigned GIE_BIT = DATA_W - 1;

  reg_sel_t         sel;
  logic             kick;
  logic [N_EVT-1:0] sts_q;
  logic [N_EVT-1:0] ien_q;
  logic             gie_q;
  logic [DATA_W-1:0] rd_mux;

  i2c_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  assign kick = wr_en && sel.kick && (wdata == DATA_W'(KICK_KEY));

  i2c_irq_status #(.N_EVT(N_EVT)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (kick),
    .evt      (evt),
    .wr_clr   (wr_en && sel.sts),
    .clr_mask (wdata[N_EVT-1:0]),
    .sts_q    (sts_q)
  );

  always_ff @(posedge clk) begin
    if (rst || kick) begin
      ien_q <= '0;
      gie_q <= 1'b0;
    end else if (wr_en) begin
      if (sel.ien) ien_q <= wdata[N_EVT-1:0];
      if (sel.gie) gie_q <= wdata[GIE_BIT];
    end
  end

  i2c_irq_out #(.N_EVT(N_EVT)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .clr_all (kick),
    .sts     (sts_q),
    .ien     (ien_q),
    .gie     (gie_q),
    .irq_q   (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) core_rst_o <= 1'b0;
    else     core_rst_o <= kick;
  end

  always_comb begin
    rd_mux = '0;
    if (sel.sts)      rd_mux = DATA_W'(sts_q);
    else if (sel.ien) rd_mux = DATA_W'(ien_q);
    else if (sel.gie) rd_mux[GIE_BIT] = gie_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end
endmodule

// File: rtl/i2c_irq_chk.sv
module i2c_irq_chk
  import i2c_irq_pkg::*;
#(
  parameter int unsigned N_EVT  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [N_EVT-1:0]  evt,
  input logic [N_EVT-1:0]  sts_q,
  input logic [N_EVT-1:0]  ien_q,
  input logic              gie_q,
  input logic              irq_o,
  input logic              core_rst_o
);
  logic key_wr, sts_wr;
  assign key_wr = wr_en && (addr == ADDR_W'(OFS_KICK)) && (wdata == DATA_W'(KICK_KEY));
  assign sts_wr = wr_en && (addr == ADDR_W'(OFS_STS));

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    ((|evt) && !key_wr) |=> ((sts_q & $past(evt)) == $past(evt))); // R2

  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && !key_wr) |=> ((sts_q & $past(wdata[N_EVT-1:0] & ~evt)) == '0)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && !key_wr && |(evt & wdata[N_EVT-1:0])) |=>
      ((sts_q & $past(evt)) == $past(evt))); // R4

  AST_GIE_GATES: assert property (@(posedge clk) disable iff (rst)
    !gie_q |=> !irq_o); // R7

  AST_KICK_PULSE: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> core_rst_o); // R8

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> (sts_q == '0 && ien_q == '0 && !gie_q)); // R8

  AST_NO_STRAY_KICK: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> !core_rst_o); // R9
endmodule

bind i2c_irq_top i2c_irq_chk #(.N_EVT(N_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .evt        (evt),
  .sts_q      (sts_q),
  .ien_q      (ien_q),
  .gie_q      (gie_q),
  .irq_o      (irq_o),
  .core_rst_o (core_rst_o)
);

// File: tb/i2c_irq_top_tb.sv
`timescale 1ns/1ps
module i2c_irq_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0;
  logic        irq_o;
  logic        core_rst_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  i2c_irq_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .irq_o(irq_o), .core_rst_o(core_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; addr = '0; d = rdata;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); evt = p;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] pats [3];
    logic gon;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 core_rst", {31'b0, core_rst_o}, 0);
    chk("R1 rdata", rdata, 0);
    rd(8'h20, v); chk("R1 status", v, 0);
    rd(8'h28, v); chk("R1 enable", v, 0);
    rd(8'h1C, v); chk("R1 gie", v, 0);

    // R5 enable register
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); chk("R5 upper bits zero", v, 32'hFF);
    wr(8'h28, 32'h5A);        rd(8'h28, v); chk("R5 readback", v, 32'h5A);
    // R11 rdata back to 0 when idle
    @(negedge clk); chk("R11 idle rdata", rdata, 0);

    // R6 global enable bit 31 only
    wr(8'h1C, 32'h7FFF_FFFF); rd(8'h1C, v); chk("R6 low bits ignored", v, 0);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); chk("R6 bit31", v, 32'h8000_0000);

    // R10 unmapped offsets
    wr(8'h24, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R10 unmapped read 0x24", v, 0);
    rd(8'h00, v); chk("R10 unmapped read 0x00", v, 0);
    rd(8'h28, v); chk("R10 enable untouched", v, 32'h5A);
    rd(8'h1C, v); chk("R10 gie untouched", v, 32'h8000_0000);
    rd(8'h40, v); chk("R10 reset reg reads 0", v, 0);

    // R9 wrong keys
    pulse(8'h3C);
    wr(8'h40, 32'h5);         chk("R9 key 0x5", {31'b0, core_rst_o}, 0);
    wr(8'h40, 32'hB);         chk("R9 key 0xB", {31'b0, core_rst_o}, 0);
    wr(8'h40, 32'h1000_000A); chk("R9 key upper set", {31'b0, core_rst_o}, 0);
    wr(8'h40, 32'hFFFF_FFFF); chk("R9 key all ones", {31'b0, core_rst_o}, 0);
    rd(8'h20, v); chk("R9 status kept", v, 32'h3C);
    rd(8'h28, v); chk("R9 enable kept", v, 32'h5A);
    @(negedge clk); chk("R7 irq with pending", {31'b0, irq_o}, 1);

    // R8 keyed soft reset
    wr(8'h40, 32'hA);
    chk("R8 pulse high", {31'b0, core_rst_o}, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, core_rst_o}, 0);
    chk("R8 irq cleared", {31'b0, irq_o}, 0);
    rd(8'h20, v); chk("R8 status cleared", v, 0);
    rd(8'h28, v); chk("R8 enable cleared", v, 0);
    rd(8'h1C, v); chk("R8 gie cleared", v, 0);

    // R3 write-one-to-clear
    pulse(8'hFF);
    wr(8'h20, 32'hA5); rd(8'h20, v); chk("R3 partial clear", v, 32'h5A);
    wr(8'h20, 32'h00); rd(8'h20, v); chk("R3 zero write keeps", v, 32'h5A);

    // R4 set wins over same-cycle clear
    wr(8'h20, 32'hFF);
    pulse(8'h02);
    @(negedge clk); evt = 8'h04; wr_en = 1'b1; addr = 8'h20; wdata = 32'h06;
    @(negedge clk); evt = 8'h00; wr_en = 1'b0; addr = '0; wdata = '0;
    rd(8'h20, v); chk("R4 set wins, other bit cleared", v, 32'h04);
    wr(8'h20, 32'hFF);

    // R7 latency
    wr(8'h28, 32'h01); wr(8'h1C, 32'h8000_0000);
    pulse(8'h01);
    chk("R7 irq lags one cycle", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R7 irq after lag", {31'b0, irq_o}, 1);
    wr(8'h1C, 32'h0); @(negedge clk);
    chk("R7 gie off gates irq", {31'b0, irq_o}, 0);

    // sweep: R2 latch pattern, R7 irq function
    for (int e = 0; e < 256; e++) begin
      gon = (e % 3) != 0;
      wr(8'h28, 32'(e));
      wr(8'h1C, gon ? 32'h8000_0000 : 32'h0);
      pats[0] = 8'(1 << (e % 8));
      pats[1] = ~8'(e);
      pats[2] = 8'((e * 53 + 7) & 8'hFF);
      for (int k = 0; k < 3; k++) begin
        wr(8'h20, 32'hFF);
        pulse(pats[k]);
        @(negedge clk);
        chk("R7 irq sweep", {31'b0, irq_o}, {31'b0, gon && ((pats[k] & 8'(e)) != 0)});
        if (k == 2) begin
          rd(8'h20, v); chk("R2 status sweep", v, {24'b0, pats[k]});
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule